// File: doc/BRIEF.md
# Correlated Double Sampling Zero Suppressor

This block sits behind the per-column converters of a pixel-matrix readout and turns one row's raw samples into a sparse list of hits. The row sequencer streams two 8-bit samples for each column in turn. The first sample is taken while the pixel still holds its charge. The second is taken right after the pixel has been cleared, so it carries only the pedestal. The block subtracts the second sample from the first, which cancels the pedestal of that pixel. It clamps a negative result to zero and compares the amplitude with a threshold held for that column. Only the columns that pass are written into an on-chip hit FIFO, each as a record with row, column and amplitude. A marker record follows the last hit of every row, so the consumer can tell where each row ends even when a row has no hits.

The sample stream comes from a sequencer with fixed row timing and cannot be stalled, so it is valid-only. The hit output is a valid/ready stream. A record is presented while `hit_valid` is high and stays unchanged until a cycle in which `hit_ready` is also high, and in that cycle it is consumed. The consumer may hold `hit_ready` low for any length of time. Back-pressure builds up in the FIFO. Once the FIFO is full, new records (hits and markers alike) are lost, and a sticky flag records the loss until it is cleared.

Top module: `cds_zero_suppressor`

## Requirements
- R1: For a column whose first sample is A and second sample is B, with A − B > 0, the hit record carries amplitude A − B (range 1..255).
- R2: A negative difference A − B is clamped to 0 and never produces a hit, not even in a column whose threshold is 0.
- R3: A column produces a hit only if its clamped amplitude is strictly greater than that column's threshold. Equality produces no hit.
- R4: The column field counts second-sample beats from 0 at the start of each row, which is after reset or after an end-of-row beat. The row field is the `smp_row` value on that column's second-sample beat.
- R5: `smp_sel` = 0 marks a first sample and 1 marks a second sample. A second sample with no pending first sample is ignored and has no effect on output or column count. A repeated first sample replaces the pending one. `smp_eor` acts only on an accepted second sample.
- R6: After the last hit of a row, the block writes one marker record with `hit_marker` = 1, column 0, amplitude 0 and the row of the end-of-row beat. Rows with no hits also produce this record.
- R7: Records leave in the order they were written. While `hit_valid` is high and `hit_ready` is low, the output record is held stable.
- R8: A record written while the FIFO holds DEPTH entries is dropped and sets `ovf_flag`. The flag stays set until `ovf_clr`. If a drop and `ovf_clr` happen in the same cycle, the set wins.
- R9: `thr_we` loads `thr_data` into the threshold of column `thr_addr`. After reset every threshold is 255, so no column can produce a hit until it is configured.
- R10: After reset `hit_valid` and `ovf_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample beat is present |
| smp_sel | input | 1 | 0 = sample before clear, 1 = sample after clear |
| smp_data | input | SAMP_W | Digitized sample |
| smp_row | input | ROW_W | Row being read out |
| smp_eor | input | 1 | Beat is the last column of the row |
| thr_we | input | 1 | Threshold write strobe |
| thr_addr | input | COL_W | Column whose threshold is written |
| thr_data | input | SAMP_W | Threshold value |
| hit_valid | output | 1 | Output record present |
| hit_ready | input | 1 | Consumer accepts the record |
| hit_marker | output | 1 | Record is an end-of-row marker |
| hit_row | output | ROW_W | Row of the record |
| hit_col | output | COL_W | Column of the hit |
| hit_amp | output | SAMP_W | Pedestal-free amplitude |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky: a record was dropped |

## Verification
The bench drives columns whose difference lands exactly on the threshold, columns with negative differences in a column whose threshold is 0, and a full-scale 255 − 0 difference. A design that used ≥ instead of >, or that compared before clamping, would emit extra hits there, and a design that lost the top bit would report a wrong amplitude. Stray second samples and repeated first samples show whether the design shifts its column count or pairs the wrong samples. A row with no hits, and a burst into a stalled consumer, show whether markers are missing, whether records past DEPTH are written over older ones, and whether the overflow flag clears itself without `ovf_clr`.

// File: rtl/cdszs_pkg.sv
package cdszs_pkg;

  typedef enum logic {
    PH_PRE  = 1'b0,
    PH_POST = 1'b1
  } phase_e;

  // Signed difference of two unsigned samples, clamped at zero.
  function automatic logic [7:0] clamp_diff8(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] d;
    d = {1'b0, a} - {1'b0, b};
    return d[8] ? 8'd0 : d[7:0];
  endfunction

endpackage

// File: rtl/cdszs_thr_bank.sv
module cdszs_thr_bank #(
  parameter int NCOL   = 128,
  parameter int SAMP_W = 8,
  localparam int COL_W = $clog2(NCOL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [SAMP_W-1:0] wr_val,
  input  logic [COL_W-1:0]  rd_col,
  output logic [SAMP_W-1:0] rd_val
);

  logic [SAMP_W-1:0] thr_q [NCOL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOL; i++) thr_q[i] <= '1;
    end else if (wr_en) begin
      thr_q[wr_col] <= wr_val;
    end
  end

  assign rd_val = thr_q[rd_col];

endmodule

// File: rtl/cdszs_diff.sv
module cdszs_diff #(
  parameter int SAMP_W = 8
) (
  input  logic [SAMP_W-1:0] pre_smp,
  input  logic [SAMP_W-1:0] post_smp,
  input  logic [SAMP_W-1:0] thresh,
  output logic [SAMP_W-1:0] amp,
  output logic              is_hit
);

  logic [SAMP_W:0] diff_s;

  generate
    if (SAMP_W == 8) begin : g_pkg
      assign diff_s = '0;
      assign amp    = cdszs_pkg::clamp_diff8(pre_smp, post_smp);
    end else begin : g_gen
      assign diff_s = {1'b0, pre_smp} - {1'b0, post_smp};
      assign amp    = diff_s[SAMP_W] ? '0 : diff_s[SAMP_W-1:0];
    end
  endgenerate

  assign is_hit = (amp > thresh);

endmodule

// File: rtl/cdszs_hit_fifo.sv
module cdszs_hit_fifo #(
  parameter int WIDTH = 26,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_rec,
  output logic             dropped,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_rec
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic             full, do_wr, do_rd;

  assign full     = (count == (AW+1)'(DEPTH));
  assign do_wr    = wr_req && !full;
  assign dropped  = wr_req && full;
  assign rd_valid = (count != '0);
  assign do_rd    = rd_valid && rd_ready;
  assign rd_rec   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_rec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/cds_zero_suppressor.sv
module cds_zero_suppressor #(
  parameter int NCOL   = 128,
  parameter int SAMP_W = 8,
  parameter int ROW_W  = 10,
  parameter int DEPTH  = 16,
  localparam int COL_W = $clog2(NCOL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              smp_sel,
  input  logic [SAMP_W-1:0] smp_data,
  input  logic [ROW_W-1:0]  smp_row,
  input  logic              smp_eor,
  input  logic              thr_we,
  input  logic [COL_W-1:0]  thr_addr,
  input  logic [SAMP_W-1:0] thr_data,
  output logic              hit_valid,
  input  logic              hit_ready,
  output logic              hit_marker,
  output logic [ROW_W-1:0]  hit_row,
  output logic [COL_W-1:0]  hit_col,
  output logic [SAMP_W-1:0] hit_amp,
  input  logic              ovf_clr,
  output logic              ovf_flag
);

  import cdszs_pkg::*;

  localparam int REC_W = 1 + ROW_W + COL_W + SAMP_W;

  // Beat decode
  logic              pre_beat, post_beat;
  logic              have_first;
  logic [SAMP_W-1:0] first_q;
  logic [COL_W-1:0]  col_q;
  logic              mark_pend;
  logic [ROW_W-1:0]  mark_row;

  assign pre_beat  = smp_valid && (phase_e'(smp_sel) == PH_PRE);
  assign post_beat = smp_valid && (phase_e'(smp_sel) == PH_POST) && have_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_first <= 1'b0;
      first_q    <= '0;
      col_q      <= '0;
      mark_pend  <= 1'b0;
      mark_row   <= '0;
    end else begin
      mark_pend <= 1'b0;
      if (pre_beat) begin
        have_first <= 1'b1;
        first_q    <= smp_data;
      end else if (post_beat) begin
        have_first <= 1'b0;
        if (smp_eor) begin
          col_q     <= '0;
          mark_pend <= 1'b1;
          mark_row  <= smp_row;
        end else if (col_q == COL_W'(NCOL-1)) begin
          col_q <= '0;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  // Threshold lookup and pedestal subtraction
  logic [SAMP_W-1:0] col_thr, amp_w;
  logic              hit_w;

  cdszs_thr_bank #(.NCOL(NCOL), .SAMP_W(SAMP_W)) u_thr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (thr_we),
    .wr_col (thr_addr),
    .wr_val (thr_data),
    .rd_col (col_q),
    .rd_val (col_thr)
  );

  cdszs_diff #(.SAMP_W(SAMP_W)) u_diff (
    .pre_smp  (first_q),
    .post_smp (smp_data),
    .thresh   (col_thr),
    .amp      (amp_w),
    .is_hit   (hit_w)
  );

  // Record assembly: a hit and a marker never fall in the same cycle,
  // because a second sample always needs a first sample after the row end.
  logic             wr_req, dropped;
  logic [REC_W-1:0] wr_rec, rd_rec;

  always_comb begin
    wr_req = 1'b0;
    wr_rec = '0;
    if (post_beat && hit_w) begin
      wr_req = 1'b1;
      wr_rec = {1'b0, smp_row, col_q, amp_w};
    end else if (mark_pend) begin
      wr_req = 1'b1;
      wr_rec = {1'b1, mark_row, {COL_W{1'b0}}, {SAMP_W{1'b0}}};
    end
  end

  cdszs_hit_fifo #(.WIDTH(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .wr_rec   (wr_rec),
    .dropped  (dropped),
    .rd_valid (hit_valid),
    .rd_ready (hit_ready),
    .rd_rec   (rd_rec)
  );

  assign {hit_marker, hit_row, hit_col, hit_amp} = rd_rec;

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (dropped) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

endmodule

// File: rtl/cdszs_checker.sv
module cdszs_checker #(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 7,
  parameter int SAMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit_valid,
  input logic              hit_ready,
  input logic              hit_marker,
  input logic [ROW_W-1:0]  hit_row,
  input logic [COL_W-1:0]  hit_col,
  input logic [SAMP_W-1:0] hit_amp,
  input logic              ovf_clr,
  input logic              ovf_flag
);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && !hit_ready |=> hit_valid && $stable(hit_marker) && $stable(hit_row)
                               && $stable(hit_col) && $stable(hit_amp));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);

  // R8
  ovf_needs_backlog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(hit_valid));

  // R6
  marker_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && hit_marker |-> hit_col == '0 && hit_amp == '0);

  // R2
  hit_amp_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && !hit_marker |-> hit_amp != '0);

endmodule

bind cds_zero_suppressor cdszs_checker #(
  .ROW_W(ROW_W), .COL_W(COL_W), .SAMP_W(SAMP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_valid  (hit_valid),
  .hit_ready  (hit_ready),
  .hit_marker (hit_marker),
  .hit_row    (hit_row),
  .hit_col    (hit_col),
  .hit_amp    (hit_amp),
  .ovf_clr    (ovf_clr),
  .ovf_flag   (ovf_flag)
);

// File: tb/cds_zero_suppressor_tb.sv
module cds_zero_suppressor_tb;

  localparam int NCOL  = 128;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0, smp_sel = 1'b0, smp_eor = 1'b0;
  logic [7:0] smp_data = '0;
  logic [9:0] smp_row = '0;
  logic       thr_we = 1'b0;
  logic [6:0] thr_addr = '0;
  logic [7:0] thr_data = '0;
  logic       hit_valid, hit_ready, hit_marker, ovf_flag;
  logic       ovf_clr = 1'b0;
  logic [9:0] hit_row;
  logic [6:0] hit_col;
  logic [7:0] hit_amp;

  always #2 clk = ~clk;

  cds_zero_suppressor #(.NCOL(NCOL), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_sel(smp_sel),
    .smp_data(smp_data), .smp_row(smp_row), .smp_eor(smp_eor),
    .thr_we(thr_we), .thr_addr(thr_addr), .thr_data(thr_data),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_marker(hit_marker),
    .hit_row(hit_row), .hit_col(hit_col), .hit_amp(hit_amp),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
  );

  typedef struct {
    logic       marker;
    logic [9:0] row;
    logic [6:0] col;
    logic [7:0] amp;
    string      tag;
  } exp_t;

  exp_t       q[$];
  int         checks = 0, fails = 0;
  int         rdy_mode = 2;
  int         tick = 0;
  logic [7:0] thr_model [NCOL];
  int         tb_col = 0;
  logic       pend_first = 1'b0;
  logic [7:0] first_val = '0;
  bit         done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Ready pattern: 0 hold low, 1 toggle, 2 always high
  always @(posedge clk) begin
    #1;
    tick++;
    hit_ready = (rdy_mode == 2) ? 1'b1 : (rdy_mode == 1) ? tick[0] : 1'b0;
  end

  // Monitor: scoreboard pop and hold-stability check
  logic       pv = 1'b0, pr = 1'b0, pm = 1'b0;
  logic [9:0] prow = '0;
  logic [6:0] pcol = '0;
  logic [7:0] pamp = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr) begin
        // R7 record held while stalled
        check(hit_valid && hit_marker == pm && hit_row == prow && hit_col == pcol
              && hit_amp == pamp, "R7", "held record", {hit_row, hit_col, hit_amp},
              {prow, pcol, pamp});
      end
      if (hit_valid && hit_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R3 R7", "unexpected record col/amp", {hit_col, hit_amp}, -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(hit_marker == e.marker && hit_row == e.row && hit_col == e.col
                && hit_amp == e.amp, e.tag, "record marker/row/col/amp",
                {hit_marker, hit_row, hit_col, hit_amp}, {e.marker, e.row, e.col, e.amp});
        end
      end
    end
    pv = hit_valid; pr = hit_ready; pm = hit_marker;
    prow = hit_row; pcol = hit_col; pamp = hit_amp;
  end

  task automatic push_exp(input logic m, input logic [9:0] r, input logic [6:0] c,
                          input logic [7:0] a, input string tag);
    exp_t e;
    e.marker = m; e.row = r; e.col = c; e.amp = a; e.tag = tag;
    if (q.size() < DEPTH) q.push_back(e);
  endtask

  task automatic beat(input logic sel, input logic [7:0] d, input logic [9:0] r,
                      input logic e);
    @(posedge clk); #1;
    smp_valid = 1'b1; smp_sel = sel; smp_data = d; smp_row = r; smp_eor = e;
    // bench model of the pairing rules
    if (!sel) begin
      pend_first = 1'b1; first_val = d;
    end else if (pend_first) begin
      int diff;
      int amp;
      pend_first = 1'b0;
      diff = int'(first_val) - int'(d);
      amp  = (diff < 0) ? 0 : diff;
      if (amp > int'(thr_model[tb_col]))
        push_exp(1'b0, r, 7'(tb_col), 8'(amp), "R1 R3 R4");
      if (e) begin
        push_exp(1'b1, r, 7'd0, 8'd0, "R6");
        tb_col = 0;
      end else begin
        tb_col = (tb_col + 1) % NCOL;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      smp_valid = 1'b0; smp_eor = 1'b0;
    end
  endtask

  task automatic column(input logic [7:0] a, input logic [7:0] b,
                        input logic [9:0] r, input logic e);
    beat(1'b0, a, r, 1'b0);
    beat(1'b1, b, r, e);
  endtask

  task automatic set_thr(input int c, input logic [7:0] v);
    @(posedge clk); #1;
    thr_we = 1'b1; thr_addr = 7'(c); thr_data = v;
    thr_model[c] = v;
    @(posedge clk); #1;
    thr_we = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 400; i++) begin
      if (q.size() == 0 && !hit_valid) break;
      @(posedge clk);
    end
    @(negedge clk);
    check(q.size() == 0 && !hit_valid, req, "all records delivered, left", q.size(), 0);
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "R7", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCOL; i++) thr_model[i] = 8'hFF;
    hit_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(!hit_valid, "R10", "hit_valid after reset", hit_valid, 0);
    check(!ovf_flag, "R10", "ovf_flag after reset", ovf_flag, 0);
    @(posedge clk); #1; rst_n = 1'b1;

    // R9 thresholds reset to 255: full-scale difference gives no hit
    column(8'd255, 8'd0, 10'd1, 1'b1);
    idle(4);
    drain("R9");

    // R9 configure thresholds
    for (int c = 0; c < NCOL; c++) set_thr(c, 8'(10 + c % 20));
    set_thr(2, 8'd0);
    set_thr(3, 8'd13);
    set_thr(4, 8'd40);

    // Main row with toggling ready: R1 R2 R3 R4
    rdy_mode = 1;
    column(8'd100, 8'd30, 10'd3, 1'b0);  // col0 amp 70 hit
    column(8'd30, 8'd100, 10'd3, 1'b0);  // col1 negative
    column(8'd50, 8'd60, 10'd3, 1'b0);   // col2 R2 negative, threshold 0
    column(8'd40, 8'd27, 10'd3, 1'b0);   // col3 R3 equal to threshold
    column(8'd90, 8'd49, 10'd3, 1'b0);   // col4 41 > 40
    column(8'd255, 8'd0, 10'd3, 1'b0);   // col5 R1 full scale
    for (int c = 6; c < 14; c++)
      column(8'((c * 29) % 256), 8'((c * 71) % 256), 10'd3, 1'b0);
    column(8'd0, 8'd255, 10'd3, 1'b1);
    idle(6);
    rdy_mode = 2;
    drain("R1 R2 R3");

    // R5 stray second samples are ignored
    beat(1'b1, 8'd0, 10'd7, 1'b0);
    beat(1'b1, 8'd0, 10'd7, 1'b1);
    idle(4);
    @(negedge clk);
    check(!hit_valid, "R5", "output after stray second samples", hit_valid, 0);
    // R5 repeated first sample replaces pending one; column stays 0
    beat(1'b0, 8'd10, 10'd7, 1'b0);
    beat(1'b0, 8'd200, 10'd7, 1'b0);
    beat(1'b1, 8'd5, 10'd7, 1'b1);
    idle(4);
    drain("R5 R4");

    // R6 row without hits still produces a marker
    for (int c = 0; c < 5; c++) column(8'd77, 8'd77, 10'd8, c == 4);
    idle(4);
    drain("R6");

    // R8 overflow with consumer stalled
    rdy_mode = 0;
    idle(2);
    for (int c = 0; c < 20; c++) set_thr(c, 8'd10);
    for (int c = 0; c < 20; c++) column(8'd60, 8'd10, 10'd9, c == 19);
    idle(5);
    @(negedge clk);
    check(ovf_flag, "R8", "ovf_flag after drop", ovf_flag, 1);
    check(q.size() == DEPTH, "R8", "bench model backlog", q.size(), DEPTH);
    idle(8);
    @(negedge clk);
    check(ovf_flag, "R8", "ovf_flag sticky", ovf_flag, 1);
    @(posedge clk); #1; ovf_clr = 1'b1;
    @(posedge clk); #1; ovf_clr = 1'b0;
    @(negedge clk);
    check(!ovf_flag, "R8", "ovf_flag after clear", ovf_flag, 0);
    rdy_mode = 2;
    idle(2);
    drain("R8 R7");

    // Normal operation resumes after overflow
    column(8'd90, 8'd20, 10'd10, 1'b1);
    idle(4);
    drain("R4 R6");
    @(negedge clk);
    check(!ovf_flag, "R8", "ovf_flag stays clear", ovf_flag, 0);

    finish_run();
  end

endmodule